// File: doc/BRIEF.md
# Value-Capturing Reorder Buffer with Rename Table

This block keeps instructions in program order between decode and retirement in an out-of-order core. Each instruction receives a slot in a circular buffer, and the slot index is its tag. The slot holds both source operands, the result and an exception flag. A rename table has one entry per architectural register, holding a present bit and a producer tag. At dispatch, each source is resolved from one of four places: the architectural register file, a finished producer still in the buffer, a completion arriving in the same cycle, or a pending tag that waits for a broadcast.

Completions arrive on a broadcast port. Each one writes the producing slot and wakes every waiting source whose tag matches. The issue-select output offers the oldest slot that has both operands and has not yet been issued. Retirement works on the oldest slot only. A clean result is written to the architectural file. A faulting result raises a trap, which empties the buffer and marks every rename entry present.

Top module: `rob_capture`

## Requirements
- R1: After reset the buffer is empty, `disp_ready` is 1, `disp_tag` is 0, and `iss_valid`, `ret_ok` and `ret_trap` are 0. All architectural registers read as 0.
- R2: Accepted dispatches take consecutive slot indices starting at the free pointer. `disp_tag` is the slot index, and it wraps from DEPTH-1 to 0.
- R3: A source whose rename entry is present takes its value from the architectural file at dispatch. Dispatching a destination makes that register's rename entry point at the new slot.
- R4: A source whose producer slot already holds its result takes that result at dispatch, without waiting for a broadcast.
- R5: A source waiting on a tag captures the broadcast value when `cmp_valid` carries a matching `cmp_tag`. The entry is not offered for issue until both sources are present.
- R6: `iss_valid`/`iss_tag` name the oldest valid, unissued slot whose two sources are present, counting from the oldest pointer across the wrap. When `iss_take` is high with `iss_valid`, that slot is marked issued and is not offered again.
- R7: When the oldest slot holds a result with `cmp_exc`=0, `ret_ok` is 1 with its tag, destination and value. At the next edge the value is written to the architectural register and the slot is freed. At most one slot retires per cycle.
- R8: When the oldest slot holds a result with `cmp_exc`=1, `ret_trap` is 1 and `disp_ready` is 0. At the next edge no register is written, every slot is flushed, and the free pointer equals the oldest pointer.
- R9: A trap marks every rename entry present, so later sources read the architectural file. Faulting values never reach that file.
- R10: With DEPTH slots occupied, `disp_ready` is 0 and `disp_valid` has no effect.
- R11: A retiring slot marks its destination's rename entry present only if that entry's tag still equals the slot index. Consumers of a newer writer keep waiting for it.
- R12: A finished slot that is not the oldest does not retire. `ret_ok` stays 0 while an older slot is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dst_en | input | 1 | Instruction writes a destination |
| disp_dst | input | AW | Destination architectural register |
| disp_src1 | input | AW | First source register |
| disp_src2 | input | AW | Second source register |
| disp_ready | output | 1 | Buffer can accept a dispatch |
| disp_tag | output | TW | Slot (tag) given to the dispatched instruction |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | TW | Tag of the completing slot |
| cmp_value | input | XLEN | Result value |
| cmp_exc | input | 1 | Result carries an exception |
| iss_take | input | 1 | Execution accepts the offered slot |
| iss_valid | output | 1 | A slot is ready to issue |
| iss_tag | output | TW | Tag of the offered slot |
| iss_a | output | XLEN | First operand of the offered slot |
| iss_b | output | XLEN | Second operand of the offered slot |
| ret_ok | output | 1 | Oldest slot retires cleanly this cycle |
| ret_trap | output | 1 | Oldest slot traps this cycle |
| ret_tag | output | TW | Tag of the oldest slot |
| ret_wen | output | 1 | Retiring slot writes a register |
| ret_dst | output | AW | Destination of the retiring slot |
| ret_value | output | XLEN | Value of the retiring slot |

## Verification
The assertions assume that `cmp_tag` names a valid, issued slot, and that each slot completes once. `iss_take` is raised only while `iss_valid` is high. Under these assumptions, the free-pointer, oldest-pointer and occupancy models in the checker track the design exactly. The directed tasks broadcast only tags that the bench itself just took from the issue port. They raise `iss_take` only after confirming the offered tag, which keeps every stimulus inside those assumptions.

// File: rtl/rob_capture.sv
module rob_capture #(
  parameter int XLEN  = 16,
  parameter int NARCH = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic                     disp_dst_en,
  input  logic [$clog2(NARCH)-1:0] disp_dst,
  input  logic [$clog2(NARCH)-1:0] disp_src1,
  input  logic [$clog2(NARCH)-1:0] disp_src2,
  output logic                     disp_ready,
  output logic [$clog2(DEPTH)-1:0] disp_tag,
  input  logic                     cmp_valid,
  input  logic [$clog2(DEPTH)-1:0] cmp_tag,
  input  logic [XLEN-1:0]          cmp_value,
  input  logic                     cmp_exc,
  input  logic                     iss_take,
  output logic                     iss_valid,
  output logic [$clog2(DEPTH)-1:0] iss_tag,
  output logic [XLEN-1:0]          iss_a,
  output logic [XLEN-1:0]          iss_b,
  output logic                     ret_ok,
  output logic                     ret_trap,
  output logic [$clog2(DEPTH)-1:0] ret_tag,
  output logic                     ret_wen,
  output logic [$clog2(NARCH)-1:0] ret_dst,
  output logic [XLEN-1:0]          ret_value
);
  localparam int TW = $clog2(DEPTH);
  localparam int AW = $clog2(NARCH);

  logic [DEPTH-1:0] e_vld, e_iss, e_done, e_exc, e_wen, s1_p, s2_p;
  logic [TW-1:0]    s1_tag [DEPTH];
  logic [TW-1:0]    s2_tag [DEPTH];
  logic [XLEN-1:0]  s1_val [DEPTH];
  logic [XLEN-1:0]  s2_val [DEPTH];
  logic [XLEN-1:0]  e_res  [DEPTH];
  logic [AW-1:0]    e_dst  [DEPTH];

  logic [NARCH-1:0] rt_p;
  logic [TW-1:0]    rt_tag [NARCH];
  logic [XLEN-1:0]  arf    [NARCH];

  logic [TW:0]   head, tail;
  logic [TW-1:0] hi, ti;
  logic          full, ret_go, dsp;

  assign hi   = head[TW-1:0];
  assign ti   = tail[TW-1:0];
  assign full = (head[TW] != tail[TW]) && (hi == ti);

  assign ret_go    = e_vld[hi] && e_done[hi];
  assign ret_ok    = ret_go && !e_exc[hi];
  assign ret_trap  = ret_go && e_exc[hi];
  assign ret_tag   = hi;
  assign ret_wen   = e_wen[hi];
  assign ret_dst   = e_dst[hi];
  assign ret_value = e_res[hi];

  assign disp_ready = !full && !ret_trap;
  assign disp_tag   = ti;
  assign dsp        = disp_valid && disp_ready;

  logic [AW-1:0]   src_r [2];
  logic            src_p [2];
  logic [TW-1:0]   src_t [2];
  logic [XLEN-1:0] src_v [2];

  assign src_r[0] = disp_src1;
  assign src_r[1] = disp_src2;

  always_comb begin
    for (int k = 0; k < 2; k++) begin
      src_t[k] = rt_tag[src_r[k]];
      src_p[k] = 1'b1;
      src_v[k] = arf[src_r[k]];
      if (!rt_p[src_r[k]]) begin
        if (e_done[src_t[k]]) src_v[k] = e_res[src_t[k]];
        else if (cmp_valid && cmp_tag == src_t[k]) src_v[k] = cmp_value;
        else begin
          src_p[k] = 1'b0;
          src_v[k] = '0;
        end
      end
    end
  end

  logic [TW-1:0] ix;
  always_comb begin
    iss_valid = 1'b0;
    iss_tag   = '0;
    ix        = '0;
    for (int k = 0; k < DEPTH; k++) begin
      ix = hi + TW'(k);
      if (!iss_valid && e_vld[ix] && !e_iss[ix] && s1_p[ix] && s2_p[ix]) begin
        iss_valid = 1'b1;
        iss_tag   = ix;
      end
    end
  end

  assign iss_a = s1_val[iss_tag];
  assign iss_b = s2_val[iss_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      e_vld <= '0;
      e_iss <= '0;
      e_done <= '0;
      e_exc <= '0;
      e_wen <= '0;
      s1_p  <= '0;
      s2_p  <= '0;
      rt_p  <= '1;
      for (int i = 0; i < DEPTH; i++) begin
        s1_tag[i] <= '0;
        s2_tag[i] <= '0;
        s1_val[i] <= '0;
        s2_val[i] <= '0;
        e_res[i]  <= '0;
        e_dst[i]  <= '0;
      end
      for (int r = 0; r < NARCH; r++) begin
        rt_tag[r] <= '0;
        arf[r]    <= '0;
      end
    end else begin
      if (cmp_valid) begin
        e_done[cmp_tag] <= 1'b1;
        e_exc[cmp_tag]  <= cmp_exc;
        e_res[cmp_tag]  <= cmp_value;
        for (int i = 0; i < DEPTH; i++) begin
          if (e_vld[i] && !s1_p[i] && s1_tag[i] == cmp_tag) begin
            s1_p[i]   <= 1'b1;
            s1_val[i] <= cmp_value;
          end
          if (e_vld[i] && !s2_p[i] && s2_tag[i] == cmp_tag) begin
            s2_p[i]   <= 1'b1;
            s2_val[i] <= cmp_value;
          end
        end
      end

      if (iss_valid && iss_take) e_iss[iss_tag] <= 1'b1;

      if (ret_ok) begin
        e_vld[hi] <= 1'b0;
        head      <= head + 1'b1;
        if (e_wen[hi]) begin
          arf[e_dst[hi]] <= e_res[hi];
          if (rt_tag[e_dst[hi]] == hi) rt_p[e_dst[hi]] <= 1'b1;
        end
      end

      if (dsp) begin
        e_vld[ti]  <= 1'b1;
        e_iss[ti]  <= 1'b0;
        e_done[ti] <= 1'b0;
        e_exc[ti]  <= 1'b0;
        e_wen[ti]  <= disp_dst_en;
        e_dst[ti]  <= disp_dst;
        s1_p[ti]   <= src_p[0];
        s1_tag[ti] <= src_t[0];
        s1_val[ti] <= src_v[0];
        s2_p[ti]   <= src_p[1];
        s2_tag[ti] <= src_t[1];
        s2_val[ti] <= src_v[1];
        if (disp_dst_en) begin
          rt_p[disp_dst]   <= 1'b0;
          rt_tag[disp_dst] <= ti;
        end
        tail <= tail + 1'b1;
      end

      if (ret_trap) begin
        e_vld <= '0;
        tail  <= head;
        rt_p  <= '1;
      end
    end
  end
endmodule

// File: rtl/rob_capture_chk.sv
module rob_capture_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     disp_valid,
  input logic                     disp_ready,
  input logic [$clog2(DEPTH)-1:0] disp_tag,
  input logic                     iss_take,
  input logic                     iss_valid,
  input logic [$clog2(DEPTH)-1:0] iss_tag,
  input logic                     ret_ok,
  input logic                     ret_trap,
  input logic [$clog2(DEPTH)-1:0] ret_tag
);
  localparam int TW = $clog2(DEPTH);

  logic [TW-1:0] m_tail, m_head;
  logic [TW:0]   m_cnt;
  logic          acc;

  assign acc = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_tail <= '0;
      m_head <= '0;
      m_cnt  <= '0;
    end else if (ret_trap) begin
      m_tail <= m_head;
      m_cnt  <= '0;
    end else begin
      if (acc) m_tail <= m_tail + 1'b1;
      if (ret_ok) m_head <= m_head + 1'b1;
      m_cnt <= m_cnt + (TW+1)'(acc) - (TW+1)'(ret_ok);
    end
  end

  AST_TAG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> disp_tag == m_tail); // R2
  AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_ok || ret_trap) |-> ret_tag == m_head); // R7
  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_ok, ret_trap})); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ret_trap |=> !iss_valid && !ret_ok && !ret_trap && disp_ready); // R8
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    m_cnt == (TW+1)'(DEPTH) |-> !disp_ready); // R10
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_cnt == '0 |-> !iss_valid && !ret_ok && !ret_trap); // R1
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_take) |=> !(iss_valid && iss_tag == $past(iss_tag))); // R6
endmodule

bind rob_capture rob_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_tag(disp_tag), .iss_take(iss_take), .iss_valid(iss_valid),
  .iss_tag(iss_tag), .ret_ok(ret_ok), .ret_trap(ret_trap), .ret_tag(ret_tag)
);

// File: tb/rob_capture_tb.sv
`timescale 1ns/1ps
module rob_capture_tb;
  localparam int XLEN = 16, NARCH = 8, DEPTH = 8;
  localparam int TW = $clog2(DEPTH), AW = $clog2(NARCH);

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_dst_en = 0;
  logic [AW-1:0] disp_dst = 0, disp_src1 = 0, disp_src2 = 0;
  logic disp_ready;
  logic [TW-1:0] disp_tag;
  logic cmp_valid = 0, cmp_exc = 0;
  logic [TW-1:0] cmp_tag = 0;
  logic [XLEN-1:0] cmp_value = 0;
  logic iss_take = 0, iss_valid;
  logic [TW-1:0] iss_tag;
  logic [XLEN-1:0] iss_a, iss_b;
  logic ret_ok, ret_trap, ret_wen;
  logic [TW-1:0] ret_tag;
  logic [AW-1:0] ret_dst;
  logic [XLEN-1:0] ret_value;

  int n_chk = 0, n_bad = 0, nxt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rob_capture #(.XLEN(XLEN), .NARCH(NARCH), .DEPTH(DEPTH)) u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    disp_valid = 0; cmp_valid = 0; cmp_exc = 0; iss_take = 0;
    #1;
  endtask

  task automatic disp(input bit en, input int dst, input int s1, input int s2);
    chk("R2", "disp_ready", disp_ready, 1);
    chk("R2", "disp_tag", disp_tag, nxt % DEPTH);
    disp_valid = 1; disp_dst_en = en;
    disp_dst = AW'(dst); disp_src1 = AW'(s1); disp_src2 = AW'(s2);
    nxt++;
    cyc();
  endtask

  task automatic iss(input string req, input int tag, input int a, input int b);
    chk(req, "iss_valid", iss_valid, 1);
    chk(req, "iss_tag", iss_tag, tag);
    chk(req, "iss_a", iss_a, a);
    chk(req, "iss_b", iss_b, b);
    iss_take = 1;
    cyc();
  endtask

  task automatic cmp(input int tag, input int val, input bit exc);
    cmp_valid = 1; cmp_tag = TW'(tag); cmp_value = XLEN'(val); cmp_exc = exc;
    cyc();
  endtask

  task automatic t_reset();
    chk("R1", "disp_ready", disp_ready, 1);
    chk("R1", "disp_tag", disp_tag, 0);
    chk("R1", "iss_valid", iss_valid, 0);
    chk("R1", "ret_ok|ret_trap", {ret_ok, ret_trap}, 0);
  endtask

  task automatic t_basic();
    disp(1, 1, 0, 0);
    iss("R1", 0, 0, 0);
    cmp(0, 'h1111, 0);
    chk("R7", "ret_ok", ret_ok, 1);
    chk("R7", "ret_tag", ret_tag, 0);
    chk("R7", "ret_dst", ret_dst, 1);
    chk("R7", "ret_wen", ret_wen, 1);
    chk("R7", "ret_value", ret_value, 'h1111);
    cyc();
    disp(1, 2, 1, 0);
    iss("R3", 1, 'h1111, 0);
    cmp(1, 'h2222, 0);
    cyc();
  endtask

  task automatic t_wakeup();
    disp(1, 3, 1, 2);
    disp(1, 4, 3, 1);
    iss("R3", 2, 'h1111, 'h2222);
    chk("R5", "iss_valid while waiting", iss_valid, 0);
    cmp(2, 'h00ab, 0);
    iss("R5", 3, 'h00ab, 'h1111);
    cmp(3, 5, 0);
    cyc();
  endtask

  task automatic t_bypass();
    disp(1, 5, 0, 0);
    disp(1, 6, 0, 0);
    iss("R6", 4, 0, 0);
    iss("R6", 5, 0, 0);
    cmp(5, 'h0066, 0);
    chk("R12", "ret_ok younger done", ret_ok, 0);
    disp(1, 7, 6, 5);
    chk("R12", "ret_ok still", ret_ok, 0);
    chk("R5", "iss_valid waiting", iss_valid, 0);
    cmp(4, 'h0055, 0);
    iss("R4", 6, 'h0066, 'h0055);
    cmp(6, 7, 0);
    cyc();
  endtask

  task automatic t_stale();
    disp(1, 2, 0, 0);
    disp(1, 2, 0, 0);
    iss("R6", 7, 0, 0);
    iss("R2", 0, 0, 0);
    cmp(7, 'h0777, 0);
    chk("R7", "ret_tag wrap", ret_tag, 7);
    chk("R7", "ret_value", ret_value, 'h0777);
    cyc();
    disp(1, 3, 2, 0);
    chk("R11", "consumer of newer writer waits", iss_valid, 0);
    cmp(0, 'h0888, 0);
    iss("R11", 1, 'h0888, 0);
    cmp(1, 1, 0);
    cyc();
  endtask

  task automatic t_trap();
    disp(1, 6, 0, 0);
    disp(1, 7, 6, 0);
    iss("R6", 2, 0, 0);
    cmp(2, 'hdead, 1);
    chk("R8", "ret_trap", ret_trap, 1);
    chk("R8", "ret_ok", ret_ok, 0);
    chk("R8", "ret_tag", ret_tag, 2);
    chk("R8", "disp_ready in trap", disp_ready, 0);
    cyc();
    chk("R8", "iss_valid after flush", iss_valid, 0);
    chk("R8", "disp_ready after flush", disp_ready, 1);
    chk("R8", "disp_tag after flush", disp_tag, 2);
    nxt = 2;
    disp(1, 1, 6, 7);
    iss("R9", 2, 'h0066, 'h0007);
    cmp(2, 'h0101, 0);
    cyc();
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) disp(1, 1, 0, 0);
    chk("R10", "disp_ready full", disp_ready, 0);
    disp_valid = 1; disp_dst_en = 1; disp_dst = 6; disp_src1 = 0; disp_src2 = 0;
    cyc();
    chk("R10", "disp_ready after ignored", disp_ready, 0);
    chk("R10", "disp_tag after ignored", disp_tag, 3);
    iss("R6", 3, 0, 0);
    chk("R6", "next oldest", iss_tag, 4);
    cmp(3, 0, 1);
    cyc();
    nxt = 3;
    disp(0, 0, 6, 1);
    iss("R9", 3, 'h0066, 'h0101);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_basic();
    t_wakeup();
    t_bypass();
    t_stale();
    t_trap();
    t_full();
    finish_run();
  end
endmodule